// File: doc/BRIEF.md
# Framed Serial Audio Port

This block is a slave-mode synchronous serial port that moves two 16-bit audio samples in each direction per frame between a host and an external codec. The codec owns the bit clock and the frame sync. The port oversamples both of them in the system clock domain. It shifts out two transmit samples, one per time slot, and assembles two receive samples.

A frame is 32 bit clocks long and is split into two 16-bit slots. A one-bit-wide, active-high frame sync marks the bit period just before slot 0. Transmit data is launched after each rising bit-clock edge. Receive data is captured on each falling edge. Both directions send the most significant bit first.

The host fills a two-entry transmit buffer and drains a two-entry receive buffer. The port gives the host these signals:
- a request strobe at the start of each slot;
- a last-slot strobe;
- a ready strobe for each received word;
- sticky underrun and overrun flags, each with its own clear input.

Both buffer indices are forced back to entry 0 at the last slot of every frame.

Top module: `fsap_top`

## Requirements
- R1: Until the first frame sync has been sampled, `sdout_o` stays 0 and none of `tx_req_o`, `last_slot_o` or `rx_rdy_o` pulses.
- R2: After a frame sync, the next 32 bit periods form one frame. Bits 0..15 carry transmit entry 0 and bits 16..31 carry entry 1, MSB first, each bit driven after the rising bit-clock edge.
- R3: Receive bits are sampled on falling bit-clock edges, MSB first. Each completed 16-bit word is stored in the entry at the receive index, sets that entry's bit in `rx_full_o`, and raises `rx_rdy_o` for one cycle, with `rx_rdy_slot_o` giving the slot (0 or 1).
- R4: `tx_req_o` pulses once at the start of each slot, with `tx_req_slot_o` equal to 0 and then 1. `last_slot_o` pulses with the slot 1 request only.
- R5: A slot that starts while its transmit entry is empty is sent as all zeros and sets `underrun_o`. The flag stays set until `underrun_clr_i` is pulsed.
- R6: A received word that lands in an entry whose `rx_full_o` bit is still set raises `overrun_o` and replaces the entry's data. The flag stays set until `overrun_clr_i` is pulsed. `rx_ack_i[n]` clears full bit n.
- R7: Each `tx_we_i` pulse writes the entry at the transmit index and advances the index by one, wrapping. At the start of slot 1 the index is forced to 0, so extra writes in one frame do not shift later frames.
- R8: The receive index advances after every stored word and is forced to 0 after the slot 1 word, so the next frame's slot 0 word lands in entry 0.
- R9: A frame sync sampled in the middle of a frame restarts the frame. The next bit is bit 0 of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Bit clock from the codec |
| fsync_i | input | 1 | Frame sync from the codec, active high |
| sdin_i | input | 1 | Serial receive data |
| sdout_o | output | 1 | Serial transmit data |
| tx_data_i | input | 16 | Transmit sample to write |
| tx_we_i | input | 1 | Write strobe for the transmit buffer |
| tx_req_o | output | 1 | Slot start pulse; asks for a refill |
| tx_req_slot_o | output | 1 | Slot number of the current request |
| last_slot_o | output | 1 | Pulse at the start of slot 1 |
| rx_data_o | output | 2x16 | Receive buffer entries 1 and 0 |
| rx_full_o | output | 2 | Unread flag for each receive entry |
| rx_ack_i | input | 2 | Per-entry read acknowledge |
| rx_rdy_o | output | 1 | Pulse when a receive word is stored |
| rx_rdy_slot_o | output | 1 | Slot of the stored word |
| underrun_o | output | 1 | Sticky transmit underrun flag |
| underrun_clr_i | input | 1 | Clears the underrun flag |
| overrun_o | output | 1 | Sticky receive overrun flag |
| overrun_clr_i | input | 1 | Clears the overrun flag |

## Verification
The assertions take three things for granted about the inputs:
- each bit-clock level lasts long enough for the edge detector to see it, which is several system clocks;
- the frame sync and receive data change only together with the rising bit-clock edge;
- a host write never targets an entry in the same cycle that the port loads it.

The stimulus keeps within this. It drives each bit-clock phase for eight system clocks and changes the codec-side lines only at rising edges. It does host writes and acknowledges only while the bit clock is paused between frames.

// File: rtl/fsap_pkg.sv
package fsap_pkg;
  localparam int unsigned NUM_SLOTS  = 2;
  localparam int unsigned SYNC_DEPTH = 2;
  typedef enum logic {SLOT_FIRST = 1'b0, SLOT_LAST = 1'b1} slot_e;
endpackage

// File: rtl/fsap_sync.sv
module fsap_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/fsap_frame.sv
module fsap_frame #(
  parameter int unsigned FRAME_BITS = 32,
  localparam int unsigned CW = $clog2(FRAME_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          fsync_i,
  output logic          armed_o,
  output logic          tx_bit_o,
  output logic [CW-1:0] tx_pos_o,
  output logic          rx_bit_o,
  output logic [CW-1:0] rx_pos_o
);
  localparam logic [CW-1:0] LAST_POS = CW'(FRAME_BITS - 1);

  logic          sclk_d, armed_q;
  logic [CW-1:0] tx_cnt_q, rx_cnt_q;
  logic          rise, fall;

  assign rise = sclk_i & ~sclk_d;
  assign fall = ~sclk_i & sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      armed_q  <= 1'b0;
      tx_cnt_q <= '0;
      rx_cnt_q <= '0;
    end else begin
      sclk_d <= sclk_i;
      if (rise && armed_q)
        tx_cnt_q <= (tx_cnt_q == LAST_POS) ? '0 : tx_cnt_q + 1'b1;
      if (fall) begin
        if (armed_q)
          rx_cnt_q <= (rx_cnt_q == LAST_POS) ? '0 : rx_cnt_q + 1'b1;
        // sync sampled on the falling edge: next rising edge is bit 0
        if (fsync_i) begin
          armed_q  <= 1'b1;
          tx_cnt_q <= '0;
          rx_cnt_q <= '0;
        end
      end
    end
  end

  assign armed_o  = armed_q;
  assign tx_bit_o = rise & armed_q;
  assign tx_pos_o = tx_cnt_q;
  assign rx_bit_o = fall & armed_q;
  assign rx_pos_o = rx_cnt_q;
endmodule

// File: rtl/fsap_tx.sv
module fsap_tx
  import fsap_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned CW = $clog2(2 * DW),
  localparam int unsigned SW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_i,
  input  logic [CW-1:0] pos_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_i,
  output logic          sdout_o,
  output logic          req_o,
  output logic          req_slot_o,
  output logic          last_o,
  output logic          underrun_o,
  output logic          widx_o
);
  logic [NUM_SLOTS-1:0][DW-1:0] mem_q;
  logic [NUM_SLOTS-1:0]         full_q;
  logic [DW-1:0]                shift_q;
  logic                         widx_q;
  logic                         start;
  slot_e                        slot;
  logic [DW-1:0]                word;

  assign start = bit_i && (pos_i[SW-1:0] == '0);
  assign slot  = slot_e'(pos_i[CW-1]);
  assign word  = full_q[slot] ? mem_q[slot] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q      <= '0;
      full_q     <= '0;
      shift_q    <= '0;
      widx_q     <= 1'b0;
      sdout_o    <= 1'b0;
      req_o      <= 1'b0;
      req_slot_o <= 1'b0;
      last_o     <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      req_o  <= 1'b0;
      last_o <= 1'b0;
      if (clr_i) underrun_o <= 1'b0;
      if (bit_i) begin
        if (start) begin
          sdout_o      <= word[DW-1];
          shift_q      <= word << 1;
          full_q[slot] <= 1'b0;
          req_o        <= 1'b1;
          req_slot_o   <= slot;
          last_o       <= (slot == SLOT_LAST);
          if (!full_q[slot]) underrun_o <= 1'b1;
        end else begin
          sdout_o <= shift_q[DW-1];
          shift_q <= shift_q << 1;
        end
      end
      if (we_i) begin
        mem_q[widx_q]  <= wdata_i;
        full_q[widx_q] <= 1'b1;
        widx_q         <= ~widx_q;
      end
      // realign host index at the last slot
      if (start && slot == SLOT_LAST) widx_q <= 1'b0;
    end
  end

  assign widx_o = widx_q;
endmodule

// File: rtl/fsap_rx.sv
module fsap_rx
  import fsap_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned CW = $clog2(2 * DW),
  localparam int unsigned SW = $clog2(DW)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         bit_i,
  input  logic [CW-1:0]                pos_i,
  input  logic                         sdin_i,
  input  logic [NUM_SLOTS-1:0]         ack_i,
  input  logic                         clr_i,
  output logic [NUM_SLOTS-1:0][DW-1:0] data_o,
  output logic [NUM_SLOTS-1:0]         full_o,
  output logic                         rdy_o,
  output logic                         rdy_slot_o,
  output logic                         overrun_o,
  output logic                         widx_o
);
  logic [NUM_SLOTS-1:0][DW-1:0] mem_q;
  logic [NUM_SLOTS-1:0]         full_q;
  logic [DW-2:0]                shift_q;
  logic                         widx_q;
  logic                         done;
  slot_e                        slot;
  logic [DW-1:0]                word;

  assign word = {shift_q, sdin_i};
  assign done = bit_i && (pos_i[SW-1:0] == '1);
  assign slot = slot_e'(pos_i[CW-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q      <= '0;
      full_q     <= '0;
      shift_q    <= '0;
      widx_q     <= 1'b0;
      rdy_o      <= 1'b0;
      rdy_slot_o <= 1'b0;
      overrun_o  <= 1'b0;
    end else begin
      rdy_o  <= 1'b0;
      full_q <= full_q & ~ack_i;
      if (clr_i) overrun_o <= 1'b0;
      if (bit_i) shift_q <= word[DW-2:0];
      if (done) begin
        mem_q[widx_q]  <= word;
        full_q[widx_q] <= 1'b1;
        if (full_q[widx_q] && !ack_i[widx_q]) overrun_o <= 1'b1;
        rdy_o      <= 1'b1;
        rdy_slot_o <= slot;
        widx_q     <= (slot == SLOT_LAST) ? 1'b0 : ~widx_q;
      end
    end
  end

  assign data_o = mem_q;
  assign full_o = full_q;
  assign widx_o = widx_q;
endmodule

// File: rtl/fsap_top.sv
module fsap_top
  import fsap_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned FRAME_BITS = NUM_SLOTS * DW,
  localparam int unsigned CW = $clog2(FRAME_BITS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sclk_i,
  input  logic                         fsync_i,
  input  logic                         sdin_i,
  output logic                         sdout_o,
  input  logic [DW-1:0]                tx_data_i,
  input  logic                         tx_we_i,
  output logic                         tx_req_o,
  output logic                         tx_req_slot_o,
  output logic                         last_slot_o,
  output logic [NUM_SLOTS-1:0][DW-1:0] rx_data_o,
  output logic [NUM_SLOTS-1:0]         rx_full_o,
  input  logic [NUM_SLOTS-1:0]         rx_ack_i,
  output logic                         rx_rdy_o,
  output logic                         rx_rdy_slot_o,
  output logic                         underrun_o,
  input  logic                         underrun_clr_i,
  output logic                         overrun_o,
  input  logic                         overrun_clr_i
);
  logic [2:0]    pins_s;
  logic          armed, tx_bit, rx_bit, sdout_raw, tx_widx, rx_widx;
  logic [CW-1:0] tx_pos, rx_pos;

  fsap_sync #(.W(3), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, fsync_i, sdin_i}),
    .q_o   (pins_s)
  );

  fsap_frame #(.FRAME_BITS(FRAME_BITS)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (pins_s[2]),
    .fsync_i (pins_s[1]),
    .armed_o (armed),
    .tx_bit_o(tx_bit),
    .tx_pos_o(tx_pos),
    .rx_bit_o(rx_bit),
    .rx_pos_o(rx_pos)
  );

  fsap_tx #(.DW(DW)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_i     (tx_bit),
    .pos_i     (tx_pos),
    .we_i      (tx_we_i),
    .wdata_i   (tx_data_i),
    .clr_i     (underrun_clr_i),
    .sdout_o   (sdout_raw),
    .req_o     (tx_req_o),
    .req_slot_o(tx_req_slot_o),
    .last_o    (last_slot_o),
    .underrun_o(underrun_o),
    .widx_o    (tx_widx)
  );

  fsap_rx #(.DW(DW)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_i     (rx_bit),
    .pos_i     (rx_pos),
    .sdin_i    (pins_s[0]),
    .ack_i     (rx_ack_i),
    .clr_i     (overrun_clr_i),
    .data_o    (rx_data_o),
    .full_o    (rx_full_o),
    .rdy_o     (rx_rdy_o),
    .rdy_slot_o(rx_rdy_slot_o),
    .overrun_o (overrun_o),
    .widx_o    (rx_widx)
  );

  assign sdout_o = sdout_raw & armed;
endmodule

// File: rtl/fsap_chk.sv
module fsap_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic armed_i,
  input logic sdout_i,
  input logic tx_req_i,
  input logic tx_req_slot_i,
  input logic last_slot_i,
  input logic rx_rdy_i,
  input logic rx_rdy_slot_i,
  input logic underrun_i,
  input logic underrun_clr_i,
  input logic overrun_i,
  input logic overrun_clr_i,
  input logic tx_widx_i,
  input logic rx_widx_i
);
  assert_quiet_before_sync_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> (!sdout_i && !tx_req_i && !last_slot_i && !rx_rdy_i));

  assert_last_with_slot1_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_slot_i |-> (tx_req_i && tx_req_slot_i));

  assert_slot1_req_is_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_i && tx_req_slot_i) |-> last_slot_i);

  assert_underrun_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_i && !underrun_clr_i) |=> underrun_i);

  assert_overrun_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_i && !overrun_clr_i) |=> overrun_i);

  assert_tx_index_realign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_slot_i |-> !tx_widx_i);

  assert_rx_index_realign_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rdy_i && rx_rdy_slot_i) |-> !rx_widx_i);
endmodule

bind fsap_top fsap_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .armed_i       (armed),
  .sdout_i       (sdout_o),
  .tx_req_i      (tx_req_o),
  .tx_req_slot_i (tx_req_slot_o),
  .last_slot_i   (last_slot_o),
  .rx_rdy_i      (rx_rdy_o),
  .rx_rdy_slot_i (rx_rdy_slot_o),
  .underrun_i    (underrun_o),
  .underrun_clr_i(underrun_clr_i),
  .overrun_i     (overrun_o),
  .overrun_clr_i (overrun_clr_i),
  .tx_widx_i     (tx_widx),
  .rx_widx_i     (rx_widx)
);

// File: tb/fsap_top_tb.sv
module fsap_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            sclk = 0, fsync = 0, sdin = 0, sdout_o;
  logic [15:0]     tx_data = '0;
  logic            tx_we = 0, tx_req_o, tx_req_slot_o, last_slot_o;
  logic [1:0][15:0] rx_data_o;
  logic [1:0]      rx_full_o, rx_ack = '0;
  logic            rx_rdy_o, rx_rdy_slot_o, underrun_o, overrun_o;
  logic            urun_clr = 0, orun_clr = 0;

  fsap_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .fsync_i(fsync), .sdin_i(sdin),
    .sdout_o(sdout_o), .tx_data_i(tx_data), .tx_we_i(tx_we), .tx_req_o(tx_req_o),
    .tx_req_slot_o(tx_req_slot_o), .last_slot_o(last_slot_o), .rx_data_o(rx_data_o),
    .rx_full_o(rx_full_o), .rx_ack_i(rx_ack), .rx_rdy_o(rx_rdy_o),
    .rx_rdy_slot_o(rx_rdy_slot_o), .underrun_o(underrun_o), .underrun_clr_i(urun_clr),
    .overrun_o(overrun_o), .overrun_clr_i(orun_clr)
  );

  int total = 0, bad = 0;
  int n_req = 0, n_last = 0, n_rdy = 0;
  logic [7:0] req_log = '0;

  always @(negedge clk) begin
    if (tx_req_o) begin
      n_req++;
      req_log <= {req_log[6:0], tx_req_slot_o};
    end
    if (last_slot_o) n_last++;
    if (rx_rdy_o) n_rdy++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_frame(input logic [15:0] a, input logic [15:0] b,
                                            input logic va, input logic vb);
    return {va ? a : 16'h0, vb ? b : 16'h0};
  endfunction

  task automatic send_bits(input logic [31:0] d, input int n, input int fs_at,
                           output logic [31:0] got);
    got = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sclk = 1; sdin = d[31-k]; fsync = (k == fs_at);
      repeat (HALF) @(negedge clk);
      got[31-k] = sdout_o;
      sclk = 0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic frame(input logic [15:0] l, input logic [15:0] r, output logic [31:0] got);
    send_bits({l, r}, 32, 31, got);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); tx_we = 1; tx_data = d;
    @(negedge clk); tx_we = 0;
  endtask

  task automatic ack_all();
    @(negedge clk); rx_ack = 2'b11;
    @(negedge clk); rx_ack = 2'b00;
  endtask

  task automatic clr_flags();
    @(negedge clk); urun_clr = 1; orun_clr = 1;
    @(negedge clk); urun_clr = 0; orun_clr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic [15:0] a, b, c, d, e, l, r;
    int r0, l0, d0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset sdout", sdout_o, 0);
    chk("R1 reset flags", {underrun_o, overrun_o, rx_full_o}, 0);

    // R1: bits with no sync yet
    r0 = n_req; l0 = n_last; d0 = n_rdy;
    send_bits($urandom, 20, -1, got);
    chk("R1 sdout zero", got, 0);
    chk("R1 no strobes", (n_req - r0) + (n_last - l0) + (n_rdy - d0), 0);

    send_bits(32'h0, 1, 0, got);  // first sync

    for (int i = 0; i < 6; i++) begin
      case (i)
        0: begin a = 16'hFFFF; b = 16'h0000; l = 16'h8001; r = 16'h7FFE; end
        1: begin a = 16'h8000; b = 16'h0001; l = 16'hFFFF; r = 16'h0000; end
        default: begin a = 16'($urandom); b = 16'($urandom); l = 16'($urandom); r = 16'($urandom); end
      endcase
      r0 = n_req; l0 = n_last; d0 = n_rdy;
      wr(a); wr(b);
      frame(l, r, got);
      chk("R2 tx frame", got, exp_frame(a, b, 1, 1));
      chk("R3 rx entry0", rx_data_o[0], {16'h0, l});
      chk("R3 rx entry1", rx_data_o[1], {16'h0, r});
      chk("R3 rx full", rx_full_o, 2'b11);
      chk("R3 rdy count", n_rdy - d0, 2);
      chk("R4 req count", n_req - r0, 2);
      chk("R4 last count", n_last - l0, 1);
      chk("R4 req order", req_log[1:0], 2'b01);
      chk("R5 no underrun", underrun_o, 0);
      chk("R6 no overrun", overrun_o, 0);
      ack_all();
      chk("R6 ack clears full", rx_full_o, 0);
    end

    // R5: no writes
    frame(16'h1234, 16'h5678, got);
    chk("R5 zeros sent", got, exp_frame(0, 0, 0, 0));
    chk("R5 underrun set", underrun_o, 1);
    repeat (20) @(negedge clk);
    chk("R5 underrun sticky", underrun_o, 1);
    @(negedge clk); urun_clr = 1; @(negedge clk); urun_clr = 0;
    chk("R5 underrun cleared", underrun_o, 0);
    ack_all();

    // R6: skip acknowledge
    wr(16'hA5A5); wr(16'h5A5A);
    frame(16'h1111, 16'h2222, got);
    chk("R6 no overrun yet", overrun_o, 0);
    wr(16'h0F0F); wr(16'hF0F0);
    frame(16'h3333, 16'h4444, got);
    chk("R6 overrun set", overrun_o, 1);
    chk("R6 newest data", rx_data_o, {16'h4444, 16'h3333});
    repeat (20) @(negedge clk);
    chk("R6 overrun sticky", overrun_o, 1);
    @(negedge clk); orun_clr = 1; @(negedge clk); orun_clr = 0;
    chk("R6 overrun cleared", overrun_o, 0);
    ack_all();

    // R7: three writes in one frame
    a = 16'($urandom); b = 16'($urandom); c = 16'($urandom);
    d = 16'($urandom); e = 16'($urandom);
    wr(a); wr(b); wr(c);
    frame(16'h0, 16'h0, got);
    chk("R7 overwritten entry", got, exp_frame(c, b, 1, 1));
    ack_all();
    wr(d); wr(e);
    frame(16'h0, 16'h0, got);
    chk("R7 realigned frame", got, exp_frame(d, e, 1, 1));
    ack_all();

    // R9 / R8: sync at bit 20 restarts the frame
    wr(16'hC3C3); wr(16'h3C3C);
    send_bits({16'hBEEF, 16'($urandom)}, 21, 20, got);
    l = 16'($urandom); r = 16'($urandom);
    frame(l, r, got);
    chk("R9 slot1 word after restart", rx_data_o[0], {16'h0, r});
    chk("R9 slot0 word after restart", rx_data_o[1], {16'h0, l});
    ack_all();
    clr_flags();
    d = 16'($urandom); e = 16'($urandom);
    l = 16'($urandom); r = 16'($urandom);
    wr(d); wr(e);
    frame(l, r, got);
    chk("R8 slot0 in entry0", rx_data_o[0], {16'h0, l});
    chk("R8 slot1 in entry1", rx_data_o[1], {16'h0, r});
    chk("R7 tx after restart", got, exp_frame(d, e, 1, 1));
    chk("R5 no underrun after refill", underrun_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule